// File: doc/BRIEF.md
# Branch Target Address Unit

This unit works out where execution continues after a jump or call. It takes the current code segment and instruction pointer, the length of the branch instruction, a branch kind code and the operands that kind needs. It then produces the new segment and pointer pair along with a one-cycle completion pulse. The kinds are an intersegment jump through an immediate segment:offset pointer, short and near relative jumps, a jump through a register, and a jump through a word in memory.

The memory case reads the target offset over a simple read port, one byte per request. The memory address is built from a data segment base and the offset held in a register, and the word is assembled low byte first. Relative, register and memory kinds keep the code segment. Only the intersegment kind changes it. A kind code with no meaning raises an error pulse and leaves the outputs alone. Storing return addresses, privilege checks and instruction fetch belong to other blocks.

Top module: `branch_target_unit`

## Requirements
- R1: After reset, done, err and mem_req are 0 and new_cs and new_ip are 0.
- R2: Kind code 0 (intersegment) loads new_cs from far_cs and new_ip from far_ip. Done pulses in the cycle after the request edge.
- R3: Kind code 1 (short) gives new_ip = cur_ip + instr_len + sign-extended disp[7:0], modulo 2^16. disp[15:8] has no effect, new_cs = cur_cs, and done follows one cycle after the request.
- R4: Kind code 2 (near) gives new_ip = cur_ip + instr_len + disp, modulo 2^16, with new_cs = cur_cs. Done follows one cycle after the request.
- R5: Kind code 3 (register) gives new_ip = reg_val and new_cs = cur_cs. Done follows one cycle after the request.
- R6: Kind code 4 (memory) issues two one-cycle mem_req pulses. The first reads physical address data_seg*16 + reg_val and the second reads data_seg*16 + ((reg_val+1) mod 2^16), both modulo 2^20. Each pulse comes the cycle after the request edge or the response before it. The word read is {second byte, first byte}, which becomes new_ip, and new_cs = the cur_cs seen at the request.
- R7: For kind code 4, done stays low until the second mem_rsp_valid. It pulses in the cycle after the edge that samples that response.
- R8: Kind codes 5, 6 and 7 pulse err in the cycle after the request. Done stays low, no mem_req is issued, and new_cs and new_ip keep their previous values.
- R9: A start that arrives while a memory read sequence is in progress is ignored: it causes no done, no err and no change of outputs.
- R10: new_cs and new_ip change only in a cycle where done is 1, and done and err are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled at the rising edge |
| kind | input | 3 | Branch kind code (0..4 defined) |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Instruction pointer of the branch instruction |
| instr_len | input | 4 | Length in bytes of the branch instruction |
| far_cs | input | 16 | Segment part of the immediate pointer |
| far_ip | input | 16 | Offset part of the immediate pointer |
| disp | input | 16 | Relative displacement (low byte used for short) |
| reg_val | input | 16 | Register operand |
| data_seg | input | 16 | Data segment for the memory kind |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle undefined-kind pulse |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | 20 | Physical byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
The bench targets the sign extension of short displacements by using negative bytes with junk in the upper half. A unit that used the full displacement or zero-extended it would land far from the expected pointer. Wraparound past FFFFh is exercised both for relative sums and for the second byte address of the memory kind. A unit that carried into the segment would fetch the wrong byte. Memory latency is varied, and a start is injected mid-sequence. An early done, a swapped byte order or a second accepted request then shows up as a cycle mismatch against the reference model. Undefined kinds are checked for untouched outputs and the absence of any memory traffic.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam logic [2:0] KIND_FAR   = 3'd0;
  localparam logic [2:0] KIND_SHORT = 3'd1;
  localparam logic [2:0] KIND_NEAR  = 3'd2;
  localparam logic [2:0] KIND_REG   = 3'd3;
  localparam logic [2:0] KIND_MEM   = 3'd4;

  typedef enum logic [1:0] {
    FETCH_IDLE  = 2'd0,
    FETCH_ISSUE = 2'd1,
    FETCH_WAIT  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/btu_target_calc.sv
module btu_target_calc
  import btu_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int LEN_W   = 4,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]       kind,
  input  logic [OFS_W-1:0] cur_cs,
  input  logic [OFS_W-1:0] cur_ip,
  input  logic [LEN_W-1:0] instr_len,
  input  logic [OFS_W-1:0] far_cs,
  input  logic [OFS_W-1:0] far_ip,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] reg_val,
  output logic [OFS_W-1:0] tgt_cs,
  output logic [OFS_W-1:0] tgt_ip,
  output logic             is_direct,
  output logic             is_mem,
  output logic             is_bad
);
  localparam int EXT_W = OFS_W - SHORT_W;

  logic [OFS_W-1:0] follow_ip;
  logic [OFS_W-1:0] short_ext;

  always_comb begin
    follow_ip = cur_ip + OFS_W'(instr_len);
    short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    tgt_cs    = cur_cs;
    tgt_ip    = cur_ip;
    is_direct = 1'b0;
    is_mem    = 1'b0;
    is_bad    = 1'b0;
    case (kind)
      KIND_FAR: begin
        tgt_cs    = far_cs;
        tgt_ip    = far_ip;
        is_direct = 1'b1;
      end
      KIND_SHORT: begin
        tgt_ip    = follow_ip + short_ext;
        is_direct = 1'b1;
      end
      KIND_NEAR: begin
        tgt_ip    = follow_ip + disp;
        is_direct = 1'b1;
      end
      KIND_REG: begin
        tgt_ip    = reg_val;
        is_direct = 1'b1;
      end
      KIND_MEM: is_mem = 1'b1;
      default:  is_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/btu_mem_fetch.sv
module btu_mem_fetch
  import btu_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch,
  input  logic [OFS_W-1:0]           seg,
  input  logic [OFS_W-1:0]           off,
  output logic                       mem_req,
  output logic [OFS_W+SEG_SHIFT-1:0] mem_addr,
  input  logic                       rsp_valid,
  input  logic [BYTE_W-1:0]          rsp_data,
  output logic                       busy,
  output logic                       word_valid,
  output logic [OFS_W-1:0]           word
);
  localparam int PHYS_W  = OFS_W + SEG_SHIFT;
  localparam int N_BYTES = OFS_W / BYTE_W;
  localparam int IDX_W   = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

  fetch_state_e     state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [OFS_W-1:0] seg_q, off_q;
  logic [OFS_W-1:0] acc_q, acc_n;
  logic [OFS_W-1:0] byte_off;
  logic             cap_en, byte_en;

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    acc_n      = acc_q;
    cap_en     = 1'b0;
    byte_en    = 1'b0;
    word_valid = 1'b0;
    case (state_q)
      FETCH_IDLE: begin
        if (launch) begin
          cap_en  = 1'b1;
          idx_n   = '0;
          acc_n   = '0;
          state_n = FETCH_ISSUE;
        end
      end
      FETCH_ISSUE: state_n = FETCH_WAIT;
      FETCH_WAIT: begin
        if (rsp_valid) begin
          byte_en = 1'b1;
          acc_n[int'(idx_q)*BYTE_W +: BYTE_W] = rsp_data;
          if (idx_q == LAST_IDX) begin
            word_valid = 1'b1;
            state_n    = FETCH_IDLE;
          end else begin
            idx_n   = idx_q + 1'b1;
            state_n = FETCH_ISSUE;
          end
        end
      end
      default: state_n = FETCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FETCH_IDLE;
      idx_q   <= '0;
      seg_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cap_en || byte_en) begin
        idx_q <= idx_n;
        acc_q <= acc_n;
      end
      if (cap_en) begin
        seg_q <= seg;
        off_q <= off;
      end
    end
  end

  assign byte_off = off_q + OFS_W'(idx_q);
  assign mem_addr = {seg_q, {SEG_SHIFT{1'b0}}} + PHYS_W'(byte_off);
  assign mem_req  = (state_q == FETCH_ISSUE);
  assign busy     = (state_q != FETCH_IDLE);
  assign word     = acc_n;
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int LEN_W     = 4,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8,
  parameter int SHORT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [2:0]                 kind,
  input  logic [OFS_W-1:0]           cur_cs,
  input  logic [OFS_W-1:0]           cur_ip,
  input  logic [LEN_W-1:0]           instr_len,
  input  logic [OFS_W-1:0]           far_cs,
  input  logic [OFS_W-1:0]           far_ip,
  input  logic [OFS_W-1:0]           disp,
  input  logic [OFS_W-1:0]           reg_val,
  input  logic [OFS_W-1:0]           data_seg,
  output logic [OFS_W-1:0]           new_cs,
  output logic [OFS_W-1:0]           new_ip,
  output logic                       done,
  output logic                       err,
  output logic                       mem_req,
  output logic [OFS_W+SEG_SHIFT-1:0] mem_addr,
  input  logic                       mem_rsp_valid,
  input  logic [BYTE_W-1:0]          mem_rsp_data
);
  logic [OFS_W-1:0] tgt_cs, tgt_ip, word;
  logic             is_direct, is_mem, is_bad;
  logic             busy, accept, launch, word_valid;
  logic [OFS_W-1:0] cs_q, cs_n, ip_q, ip_n, hold_cs_q;
  logic             done_q, done_n, err_q, err_n, out_en;

  btu_target_calc #(.OFS_W(OFS_W), .LEN_W(LEN_W), .SHORT_W(SHORT_W)) i_calc (
    .kind(kind), .cur_cs(cur_cs), .cur_ip(cur_ip), .instr_len(instr_len),
    .far_cs(far_cs), .far_ip(far_ip), .disp(disp), .reg_val(reg_val),
    .tgt_cs(tgt_cs), .tgt_ip(tgt_ip),
    .is_direct(is_direct), .is_mem(is_mem), .is_bad(is_bad)
  );

  btu_mem_fetch #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .BYTE_W(BYTE_W)) i_fetch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .seg(data_seg), .off(reg_val),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .busy(busy), .word_valid(word_valid), .word(word)
  );

  always_comb begin
    accept = start && !busy;
    launch = accept && is_mem;
    done_n = (accept && is_direct) || word_valid;
    err_n  = accept && is_bad;
    out_en = done_n;
    cs_n   = cs_q;
    ip_n   = ip_q;
    if (word_valid) begin
      cs_n = hold_cs_q;
      ip_n = word;
    end else if (accept && is_direct) begin
      cs_n = tgt_cs;
      ip_n = tgt_ip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= '0;
      ip_q      <= '0;
      hold_cs_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
      if (out_en) begin
        cs_q <= cs_n;
        ip_q <= ip_n;
      end
      if (launch) hold_cs_q <= cur_cs;
    end
  end

  assign new_cs = cs_q;
  assign new_ip = ip_q;
  assign done   = done_q;
  assign err    = err_q;
endmodule

// File: rtl/branch_target_unit_chk.sv
module branch_target_unit_chk #(
  parameter int OFS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       kind,
  input logic [OFS_W-1:0] far_cs,
  input logic [OFS_W-1:0] far_ip,
  input logic [OFS_W-1:0] new_cs,
  input logic [OFS_W-1:0] new_ip,
  input logic             done,
  input logic             err,
  input logic             mem_req,
  input logic             busy
);
  p_far_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind == 3'd0) |=> (done && new_cs == $past(far_cs) && new_ip == $past(far_ip)));

  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_no_done_during_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done);

  p_bad_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind > 3'd4) |=> (err && !done && !mem_req));

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !err);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_cs) && $stable(new_ip)));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind branch_target_unit branch_target_unit_chk #(.OFS_W(OFS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
  .far_cs(far_cs), .far_ip(far_ip), .new_cs(new_cs), .new_ip(new_ip),
  .done(done), .err(err), .mem_req(mem_req), .busy(busy)
);

// File: tb/test_branch_target_unit.sv
module test_branch_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] cur_cs = '0, cur_ip = '0, far_cs = '0, far_ip = '0;
  logic [15:0] disp = '0, reg_val = '0, data_seg = '0;
  logic [3:0]  instr_len = '0;
  logic [15:0] new_cs, new_ip;
  logic        done, err, mem_req;
  logic [19:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit   model_on = 1'b0;
  int   latency = 1;

  always #5 clk = ~clk;

  branch_target_unit i_branch_target_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .instr_len(instr_len),
    .far_cs(far_cs), .far_ip(far_ip), .disp(disp), .reg_val(reg_val),
    .data_seg(data_seg), .new_cs(new_cs), .new_ip(new_ip),
    .done(done), .err(err), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
  endfunction

  // behavioural reference model
  int          phase = 0;
  logic        e_done = 0, e_err = 0;
  logic [15:0] e_cs = 0, e_ip = 0, m_seg = 0, m_off = 0, m_cs = 0;
  logic [7:0]  m_lo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; e_done = 0; e_err = 0; e_cs = 0; e_ip = 0;
    end else begin
      e_done = 0; e_err = 0;
      case (phase)
        0: if (start) begin
          if (kind == 0) begin e_cs = far_cs; e_ip = far_ip; e_done = 1; end
          else if (kind == 1) begin
            e_cs = cur_cs;
            e_ip = 16'(int'(cur_ip) + int'(instr_len) + int'($signed(disp[7:0]))); e_done = 1;
          end else if (kind == 2) begin
            e_cs = cur_cs; e_ip = 16'(int'(cur_ip) + int'(instr_len) + int'(disp)); e_done = 1;
          end else if (kind == 3) begin e_cs = cur_cs; e_ip = reg_val; e_done = 1; end
          else if (kind == 4) begin m_seg = data_seg; m_off = reg_val; m_cs = cur_cs; phase = 1; end
          else e_err = 1;
        end
        1: phase = 2;
        2: if (mem_rsp_valid) begin m_lo = mem_rsp_data; phase = 3; end
        3: phase = 4;
        default: if (mem_rsp_valid) begin
          e_ip = {mem_rsp_data, m_lo}; e_cs = m_cs; e_done = 1; phase = 0;
        end
      endcase
    end
  end

  function automatic logic [19:0] model_addr();
    logic [15:0] o;
    o = (phase == 3) ? m_off + 16'd1 : m_off;
    return 20'({m_seg, 4'h0}) + 20'(o);
  endfunction

  // memory responder and per-cycle comparison
  int          cnt = 0;
  logic [19:0] lat_addr = 0;
  always @(negedge clk) begin
    logic e_req;
    mem_rsp_valid <= 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin mem_rsp_valid <= 1'b1; mem_rsp_data <= mem_byte(lat_addr); end
    end
    if (mem_req) begin cnt = latency; lat_addr = mem_addr; end
    if (model_on && rst_n) begin
      e_req = (phase == 1 || phase == 3);
      checks++;
      if (done !== e_done || err !== e_err || new_cs !== e_cs || new_ip !== e_ip ||
          mem_req !== e_req || (e_req && mem_addr !== model_addr())) begin
        errors++;
        $display("FAIL %s cycle: done/err/cs/ip/req/addr act %b %b %h %h %b %h exp %b %b %h %h %b %h",
                 tag, done, err, new_cs, new_ip, mem_req, mem_addr,
                 e_done, e_err, e_cs, e_ip, e_req, model_addr());
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", t, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k);
    @(negedge clk);
    kind = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 reset", {done, err, mem_req, new_cs, new_ip[12:0]}, 32'h0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk("R1 after release", {done, err, mem_req}, 32'h0);

    tag = "R2";
    cur_cs = 16'h0040; cur_ip = 16'h0010; instr_len = 4'd5;
    far_cs = 16'h1000; far_ip = 16'h0000;
    issue(3'd0);
    chk("R2 done", done, 1); chk("R2 cs", new_cs, 16'h1000); chk("R2 ip", new_ip, 16'h0000);
    tag = "R10"; wait_end(2);
    chk("R10 hold cs", new_cs, 16'h1000);

    tag = "R3";
    cur_cs = 16'h2222; cur_ip = 16'h0100; instr_len = 4'd2; disp = 16'h0002;
    issue(3'd1);
    chk("R3 fwd ip", new_ip, 16'h0104); chk("R3 cs kept", new_cs, 16'h2222);
    cur_ip = 16'h0200; disp = 16'hABFE;
    issue(3'd1);
    chk("R3 negative ip", new_ip, 16'h0200);
    cur_ip = 16'hFFF0; disp = 16'h007F;
    issue(3'd1);
    chk("R3 wrap ip", new_ip, 16'h0071);

    tag = "R4";
    cur_ip = 16'h1000; instr_len = 4'd3; disp = 16'h8000;
    issue(3'd2);
    chk("R4 ip", new_ip, 16'h9003);
    cur_ip = 16'hFFFE; disp = 16'h0005;
    issue(3'd2);
    chk("R4 wrap ip", new_ip, 16'h0006);

    tag = "R5";
    cur_cs = 16'h3333; reg_val = 16'hBEEF;
    issue(3'd3);
    chk("R5 ip", new_ip, 16'hBEEF); chk("R5 cs", new_cs, 16'h3333);

    tag = "R8";
    for (int k = 5; k < 8; k++) begin
      issue(3'(k));
      chk("R8 err", {err, done, mem_req}, 32'h4);
      chk("R8 ip kept", new_ip, 16'hBEEF);
    end

    tag = "R6";
    cur_cs = 16'h4444; data_seg = 16'h0100; reg_val = 16'h1000; latency = 1;
    issue(3'd4);
    cur_cs = 16'h5555;
    wait_end(6);
    chk("R6 ip", new_ip, {mem_byte(20'h02001), mem_byte(20'h02000)});
    chk("R6 cs", new_cs, 16'h4444);

    tag = "R7";
    latency = 4; data_seg = 16'hF000; reg_val = 16'hFFFF;
    issue(3'd4);
    wait_end(3);
    chk("R7 no early done", done, 0);
    wait_end(10);
    chk("R7 wrap ip", new_ip, {mem_byte(20'hF0000), mem_byte(20'hFFFFF)});

    tag = "R9";
    latency = 3; data_seg = 16'h0010; reg_val = 16'h0020;
    issue(3'd4);
    far_cs = 16'h7777; far_ip = 16'h8888;
    issue(3'd0);
    issue(3'd6);
    wait_end(10);
    chk("R9 cs", new_cs, 16'h5555);
    chk("R9 ip", new_ip, {mem_byte(20'h00121), mem_byte(20'h00120)});

    tag = "R10";
    wait_end(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule